// File: doc/BRIEF.md
# Burst Dimming Generator with Soft-Start Ceiling

This block sets lamp brightness by switching the lamp drive on and off at a low rate. It produces a burst gate: while the gate is high the lamp inverter runs, and while it is low the drive is stopped. The fraction of time the gate is high sets the perceived brightness. The block also produces a soft-start ceiling, which is a limit on the drive strength for the lamp regulator. The ceiling starts at zero when each burst begins and climbs one fixed step per lamp cycle, so the lamp current rises gradually instead of jumping.

The gate has two selectable sources. In internal mode, a free-running phase counter sets the burst period in clock cycles, and a digital brightness code sets the duty. A slope control can invert the code. A floor on the code keeps a short burst even at minimum brightness. For example, with a 100 kHz dimming clock, a period of 500 gives a 200 Hz burst. Programmed periods span 80 Hz to 300 Hz bursts, and the duty covers 100% down to below 10%. In external mode, an asynchronous PWM pin is synchronised and passed straight to the gate, and the code and slope inputs have no effect.

Top module: `burst_dimmer`

## Requirements
- R1: During and right after reset, `burst_gate` is 0 and `ss_ceiling` is 0.
- R2: When `ext_mode` is 0 the gate comes from the internal generator. When it is 1 the gate comes from `ext_pwm`, and `level_code` and `invert_slope` have no effect on either output.
- R3: The effective code equals `level_code` when `invert_slope` is 0, and equals its bitwise complement when `invert_slope` is 1. A code of all zeros with `invert_slope`=1 therefore gives full brightness.
- R4: In internal mode with steady inputs, the gate is high for exactly floor(`period_len` × (c+1) / 2^CODE_W) cycles of every period. Here c is the effective code after the floor in R5. With CODE_W=8, an effective code of 255 holds the gate high all the time.
- R5: An effective code below MIN_CODE (16 by default) is treated as MIN_CODE, so a zero code still gives a nonzero burst. With `period_len`=100 this is 6 high cycles per period.
- R6: In internal mode, the gate pattern repeats every `period_len` clock cycles, for `period_len` of at least 2. Consecutive rising edges are `period_len` cycles apart.
- R7: In external mode, a change on `ext_pwm` appears on `burst_gate` at the third rising clock edge after it, and not earlier.
- R8: `ss_ceiling` is 0 while `burst_gate` is low, and it is still 0 on the cycle after `burst_gate` rises.
- R9: While `burst_gate` stays high, each cycle with `lamp_tick` high raises `ss_ceiling` by SS_STEP (32 by default). The value saturates at 2^CEIL_W−1 (255), and it never falls within a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dimming clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0: internal generator, 1: external PWM pin |
| level_code | input | CODE_W (8) | Digital brightness code |
| invert_slope | input | 1 | 1 inverts the brightness code |
| period_len | input | PERIOD_W (20) | Burst period in clock cycles |
| ext_pwm | input | 1 | Asynchronous external dimming PWM |
| lamp_tick | input | 1 | One-cycle strobe per lamp cycle |
| burst_gate | output | 1 | Registered lamp-drive enable |
| ss_ceiling | output | CEIL_W (8) | Registered soft-start drive ceiling |

## Verification
A wrong phase counter or duty product shows up as a gate high-time or a rising-edge spacing that is off by at least one cycle within the first full period. A broken slope inversion or code floor swaps or removes the burst in the same window. A missing or extra synchroniser stage moves the external-mode gate edge one cycle away from the third edge. A ceiling that fails to restart, skips a step or wraps past full scale is visible on `ss_ceiling` at the next `lamp_tick` of the burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } gate_src_e;
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/burst_gen.sv
module burst_gen #(
  parameter int CODE_W   = 8,
  parameter int PERIOD_W = 20,
  parameter int MIN_CODE = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CODE_W-1:0]   level_code,
  input  logic                invert_slope,
  input  logic [PERIOD_W-1:0] period_len,
  output logic                int_gate
);
  localparam int PROD_W = PERIOD_W + CODE_W + 1;
  localparam int ON_W   = PERIOD_W + 1;
  localparam logic [CODE_W-1:0] FLOOR = CODE_W'(MIN_CODE);

  logic [PERIOD_W-1:0] phase;
  logic [CODE_W-1:0]   eff_code;
  logic [CODE_W-1:0]   floored;
  logic [PROD_W-1:0]   product;
  logic [ON_W-1:0]     on_len;
  logic                wrap;

  always_comb begin
    eff_code = invert_slope ? ~level_code : level_code;
    floored  = (eff_code < FLOOR) ? FLOOR : eff_code;
    product  = PROD_W'(period_len) * (PROD_W'(floored) + PROD_W'(1));
    on_len   = ON_W'(product >> CODE_W);
    wrap     = (period_len <= PERIOD_W'(1)) || (phase >= period_len - PERIOD_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      int_gate <= 1'b0;
    end else begin
      phase    <= wrap ? '0 : phase + PERIOD_W'(1);
      int_gate <= (ON_W'(phase) < on_len);
    end
  end

  // R6: phase stays inside the programmed period once it is there
  p_phase_range_r6: assert property (@(posedge clk) disable iff (rst)
    ($stable(period_len) && period_len >= PERIOD_W'(2) && $past(phase) < period_len)
      |-> phase < period_len);
endmodule

// File: rtl/softstart_ramp.sv
module softstart_ramp #(
  parameter int CEIL_W  = 8,
  parameter int SS_STEP = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic              lamp_tick,
  output logic [CEIL_W-1:0] ceiling
);
  localparam logic [CEIL_W-1:0] FULL = {CEIL_W{1'b1}};
  localparam logic [CEIL_W-1:0] STEP = CEIL_W'(SS_STEP);

  logic gate_prev;
  logic rising;

  assign rising = gate && !gate_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_prev <= 1'b0;
      ceiling   <= '0;
    end else begin
      gate_prev <= gate;
      if (!gate || rising)
        ceiling <= '0;
      else if (lamp_tick)
        ceiling <= (ceiling > FULL - STEP) ? FULL : ceiling + STEP;
    end
  end

  // R8: a new burst always opens with a zero ceiling
  p_ceil_restart_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |=> ceiling == '0);
  // R9: within a burst the ceiling never drops
  p_ceil_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    (gate && $past(gate) && $past(gate, 2)) |-> ceiling >= $past(ceiling));
  // R9: the ceiling climbs by at most one step per cycle
  p_ceil_step_r9: assert property (@(posedge clk) disable iff (rst)
    (ceiling >= $past(ceiling)) |-> (ceiling - $past(ceiling)) <= STEP);
endmodule

// File: rtl/burst_dimmer.sv
module burst_dimmer #(
  parameter int CODE_W   = 8,
  parameter int PERIOD_W = 20,
  parameter int MIN_CODE = 16,
  parameter int CEIL_W   = 8,
  parameter int SS_STEP  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext_mode,
  input  logic [CODE_W-1:0]   level_code,
  input  logic                invert_slope,
  input  logic [PERIOD_W-1:0] period_len,
  input  logic                ext_pwm,
  input  logic                lamp_tick,
  output logic                burst_gate,
  output logic [CEIL_W-1:0]   ss_ceiling
);
  import burst_pkg::*;

  gate_src_e src;
  logic      int_gate;
  logic      ext_sync;

  assign src = gate_src_e'(ext_mode);

  burst_gen #(
    .CODE_W(CODE_W), .PERIOD_W(PERIOD_W), .MIN_CODE(MIN_CODE)
  ) u_gen (
    .clk(clk), .rst(rst), .level_code(level_code),
    .invert_slope(invert_slope), .period_len(period_len), .int_gate(int_gate)
  );

  pwm_sync u_sync (
    .clk(clk), .rst(rst), .async_in(ext_pwm), .sync_out(ext_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) burst_gate <= 1'b0;
    else     burst_gate <= (src == SRC_EXTERNAL) ? ext_sync : int_gate;
  end

  softstart_ramp #(
    .CEIL_W(CEIL_W), .SS_STEP(SS_STEP)
  ) u_ramp (
    .clk(clk), .rst(rst), .gate(burst_gate),
    .lamp_tick(lamp_tick), .ceiling(ss_ceiling)
  );

  // Cycles since reset, for assertions that look back several cycles
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R7: external gate equals the pin three edges earlier
  p_ext_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && $past(ext_mode)) |-> burst_gate == $past(ext_pwm, 3));
  // R1: outputs are cleared in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!burst_gate && ss_ceiling == '0));
  // R8: no ceiling while the gate is off
  p_ceil_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!burst_gate && since_rst >= 3'd1) |=> ss_ceiling == '0);
endmodule

// File: tb/test_burst_dimmer.sv
module test_burst_dimmer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b0;
  logic [7:0]  level_code = 8'd0;
  logic        invert_slope = 1'b0;
  logic [19:0] period_len = 20'd100;
  logic        ext_pwm = 1'b0;
  logic        lamp_tick = 1'b0;
  logic        burst_gate;
  logic [7:0]  ss_ceiling;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_dimmer i_burst_dimmer (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .level_code(level_code),
    .invert_slope(invert_slope), .period_len(period_len), .ext_pwm(ext_pwm),
    .lamp_tick(lamp_tick), .burst_gate(burst_gate), .ss_ceiling(ss_ceiling)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // high cycles over one full period (period_len samples)
  task automatic count_high(output int hi);
    hi = 0;
    for (int i = 0; i < int'(period_len); i++) begin
      step(1);
      if (burst_gate) hi++;
    end
  endtask

  task automatic internal_duty(string req, logic [7:0] code, logic inv,
                               logic [19:0] per, int expected);
    int hi;
    ext_mode = 1'b0; level_code = code; invert_slope = inv; period_len = per;
    step(2 * int'(per) + 4);
    count_high(hi);
    check(req, hi, expected);
  endtask

  task automatic t_reset;
    step(3);
    check("R1 gate in reset", int'(burst_gate), 0);
    check("R1 ceiling in reset", int'(ss_ceiling), 0);
    rst = 1'b0;
    step(1);
    check("R1 gate after reset", int'(burst_gate), 0);
    check("R1 ceiling after reset", int'(ss_ceiling), 0);
  endtask

  task automatic t_slope_and_duty;
    internal_duty("R4 code128 slope0", 8'd128, 1'b0, 20'd100, 50);
    internal_duty("R3 code64 slope0", 8'd64, 1'b0, 20'd100, 25);
    internal_duty("R3 code64 slope1", 8'd64, 1'b1, 20'd100, 75);
    internal_duty("R4 full code", 8'd255, 1'b0, 20'd100, 100);
    internal_duty("R3 zero code inverted is full", 8'd0, 1'b1, 20'd100, 100);
  endtask

  task automatic t_floor;
    internal_duty("R5 zero code floor", 8'd0, 1'b0, 20'd100, 6);
    internal_duty("R5 inverted top code floor", 8'd255, 1'b1, 20'd100, 6);
  endtask

  task automatic t_period;
    int gap;
    internal_duty("R4 code128 period40", 8'd128, 1'b0, 20'd40, 20);
    // wait for a rising edge, then time the next one
    while (!(burst_gate == 1'b0)) step(1);
    while (burst_gate == 1'b0) step(1);
    gap = 0;
    do begin step(1); gap++; end while (!(burst_gate == 1'b0));
    while (burst_gate == 1'b0) begin step(1); gap++; end
    check("R6 rise spacing period40", gap, 40);
  endtask

  task automatic t_external;
    int bad;
    ext_mode = 1'b1; ext_pwm = 1'b0;
    step(5);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      level_code = 8'(i * 37); invert_slope = i[0];
      step(1);
      if (burst_gate || ss_ceiling != 8'd0) bad++;
    end
    check("R2 code and slope ignored", bad, 0);
    ext_pwm = 1'b1;
    step(2);
    check("R7 gate not yet at edge 2", int'(burst_gate), 0);
    step(1);
    check("R7 gate at edge 3", int'(burst_gate), 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      level_code = 8'(i * 11); invert_slope = ~i[0];
      step(1);
      if (!burst_gate) bad++;
    end
    check("R2 external high holds", bad, 0);
  endtask

  task automatic pulse_tick;
    lamp_tick = 1'b1;
    step(1);
    lamp_tick = 1'b0;
    step(2);
  endtask

  task automatic t_softstart;
    int exp_c;
    ext_mode = 1'b1; ext_pwm = 1'b0;
    step(6);
    check("R8 ceiling zero while off", int'(ss_ceiling), 0);
    ext_pwm = 1'b1;
    step(3);
    step(1);
    check("R8 ceiling zero after rise", int'(ss_ceiling), 0);
    exp_c = 0;
    for (int k = 1; k <= 10; k++) begin
      pulse_tick();
      exp_c = (exp_c + 32 > 255) ? 255 : exp_c + 32;
      check($sformatf("R9 ceiling after tick %0d", k), int'(ss_ceiling), exp_c);
    end
    ext_pwm = 1'b0;
    step(5);
    check("R8 ceiling cleared when off", int'(ss_ceiling), 0);
    ext_pwm = 1'b1;
    step(4);
    check("R8 restart at zero", int'(ss_ceiling), 0);
    pulse_tick();
    check("R9 first step of new burst", int'(ss_ceiling), 32);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_slope_and_duty();
    t_floor();
    t_period();
    t_external();
    t_softstart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule